// File: doc/BRIEF.md
# Two-Dimensional Video Scan Handle Generator

This block walks a rectangular or sheared window origin ("handle") across a two-dimensional data map. It needs no instruction stream. Two identical one-dimensional slider units, one for x and one for y, advance in lock-step. Each unit holds three positions:

- an origin that marks where each line starts;
- a span that marks where each line stops;
- the running address.

Within a line, both running addresses move by their own step on each produced handle. When either unit's next address would pass its span, the line ends. Both origins and spans then move by their own steps, and both addresses restart from the moved origins. The scan terminates at such a line end if, in either dimension, a moved origin or moved span reaches its end bound. A down counter can optionally end the scan earlier.

Every handle goes through an address mapper. The mapper packs y above a programmed bit shift and x below it, forming one linear memory address. The handle is presented on a valid/ready port. Handles whose coordinates cannot be packed are silently skipped. A save strobe copies the live generator state into shadow registers. A later start with the resume select set continues from that copy instead of from the programmed origins. A stop input abandons a run without signalling completion.

Top module: `scan_handle_gen`

## Requirements
- R1: After reset, out_valid_o, done_o and busy_o are 0, and saved_cnt_o is 0.
- R2: A start_i pulse with resume_i=0 makes busy_o high on the next cycle, and presents the handle (x_org_i, y_org_i) as the first position.
- R3: Within a line, each consumed handle moves x by x_step_i and y by y_step_i together.
- R4: A line ends when either dimension's next address would lie strictly beyond its current span, in the direction of its step. A zero step never ends a line. At a line end, each origin moves by its origin step, each span moves by its span step, and both addresses restart at the moved origins.
- R5: At a line end, the scan terminates if, in either dimension, the moved origin reaches or passes its origin end bound, or the moved span reaches or passes its span end bound. Each comparison is made in the direction of the respective step, and a zero step never triggers. done_o is then high for exactly one cycle, the cycle after the last handle is consumed, and busy_o is low in that cycle.
- R6: With end_sel_i=1 and a nonzero cnt_init_i=N, the scan terminates after N generated positions, counting skipped ones, unless R5 stops it first. A count of 0, or end_sel_i=0, leaves the counter with no effect on termination.
- R7: While out_valid_o is high and out_ready_i is low, the presented handle and address stay unchanged and valid stays high.
- R8: out_addr_o equals (y << shift_i) | x, zero-extended to AW bits.
- R9: A handle is skipped without being presented, consuming one cycle with no handshake, if any of these holds: a coordinate is negative, x ≥ 2^shift_i, or (y << shift_i) ≥ 2^AW.
- R10: save_i captures the generator state that will be current after that clock edge, including the counter. A save that coincides with an accepted transfer therefore holds the position that follows it. saved_cnt_o shows the captured count.
- R11: A start_i pulse with resume_i=1 reloads all positions and the counter from the saved state, and presents the saved position first.
- R12: stop_i ends a run on the next cycle (busy_o and out_valid_o low) and no done_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| resume_i | input | 1 | With start_i: load from saved state instead of programmed origins |
| stop_i | input | 1 | Abandon the current run |
| save_i | input | 1 | Capture state into the shadow registers |
| end_sel_i | input | 1 | 1: counter may also terminate the scan |
| cnt_init_i | input | NW | Position count loaded on a fresh start |
| shift_i | input | SW | Bit position of y in the linear address |
| x_org_i | input | CW | Initial x origin (signed) |
| x_span_i | input | CW | Initial x span (signed) |
| x_step_i | input | CW | x address step |
| x_org_step_i | input | CW | x origin step per line |
| x_span_step_i | input | CW | x span step per line |
| x_org_end_i | input | CW | x origin end bound |
| x_span_end_i | input | CW | x span end bound |
| y_org_i | input | CW | Initial y origin (signed) |
| y_span_i | input | CW | Initial y span (signed) |
| y_step_i | input | CW | y address step |
| y_org_step_i | input | CW | y origin step per line |
| y_span_step_i | input | CW | y span step per line |
| y_org_end_i | input | CW | y origin end bound |
| y_span_end_i | input | CW | y span end bound |
| out_ready_i | input | 1 | Consumer accepts the handle |
| out_valid_o | output | 1 | A handle is presented |
| out_x_o | output | CW | Handle x |
| out_y_o | output | CW | Handle y |
| out_addr_o | output | AW | Packed linear address |
| done_o | output | 1 | One-cycle pulse on termination |
| busy_o | output | 1 | A run is active |
| saved_cnt_o | output | NW | Counter value held in the shadow copy |

## Verification
The delicate coincidence is a save strobe landing in the same cycle as an accepted transfer. The captured state must then be the position after the accepted one, with the counter already decremented. The bench provokes this directly: it asserts save_i and out_ready_i together while the third handle of a counted scan is presented. It then expects a saved count of 7 of 10, stops the run, and resumes. It judges the result by whether the first resumed handle is the fourth position, and by whether the remaining seven handles end on the expected final address with a done pulse.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    END_ESCAPE    = 1'b0,
    END_ESC_OR_CNT = 1'b1
  } end_sel_e;

  // true when val lies beyond bnd in the direction of stp; zero step never
  function automatic logic beyond(input int val, input int bnd, input int stp,
                                  input logic incl);
    logic r;
    if (stp == 0)     r = 1'b0;
    else if (stp > 0) r = incl ? (val >= bnd) : (val > bnd);
    else              r = incl ? (val <= bnd) : (val < bnd);
    return r;
  endfunction

endpackage

// File: rtl/scan_slider.sv
module scan_slider #(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic                 resume_i,
  input  logic                 adv_i,
  input  logic                 wrap_i,
  input  logic                 save_i,
  input  logic signed [CW-1:0] org_i,
  input  logic signed [CW-1:0] span_i,
  input  logic signed [CW-1:0] step_i,
  input  logic signed [CW-1:0] org_step_i,
  input  logic signed [CW-1:0] span_step_i,
  input  logic signed [CW-1:0] org_end_i,
  input  logic signed [CW-1:0] span_end_i,
  output logic signed [CW-1:0] pos_o,
  output logic                 line_esc_o,
  output logic                 frame_esc_o
);
  import scan_pkg::*;

  logic signed [CW-1:0] org_q, span_q, addr_q;
  logic signed [CW-1:0] org_d, span_d, addr_d;
  logic signed [CW-1:0] sv_org_q, sv_span_q, sv_addr_q;
  logic signed [CW-1:0] addr_n, org_n, span_n;

  assign addr_n = addr_q + step_i;
  assign org_n  = org_q + org_step_i;
  assign span_n = span_q + span_step_i;

  assign line_esc_o  = beyond(int'(addr_n), int'(span_q), int'(step_i), 1'b0);
  assign frame_esc_o = beyond(int'(org_n), int'(org_end_i), int'(org_step_i), 1'b1)
                     | beyond(int'(span_n), int'(span_end_i), int'(span_step_i), 1'b1);
  assign pos_o = addr_q;

  always_comb begin
    org_d  = org_q;
    span_d = span_q;
    addr_d = addr_q;
    if (init_i) begin
      org_d  = org_i;
      span_d = span_i;
      addr_d = org_i;
    end else if (resume_i) begin
      org_d  = sv_org_q;
      span_d = sv_span_q;
      addr_d = sv_addr_q;
    end else if (adv_i) begin
      if (wrap_i) begin
        org_d  = org_n;
        span_d = span_n;
        addr_d = org_n;
      end else begin
        addr_d = addr_n;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_q     <= '0;
      span_q    <= '0;
      addr_q    <= '0;
      sv_org_q  <= '0;
      sv_span_q <= '0;
      sv_addr_q <= '0;
    end else begin
      org_q  <= org_d;
      span_q <= span_d;
      addr_q <= addr_d;
      if (save_i) begin
        sv_org_q  <= org_d;
        sv_span_q <= span_d;
        sv_addr_q <= addr_d;
      end
    end
  end

  // R4: after a line wrap the address sits on the origin
  p_line_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && wrap_i && !init_i && !resume_i |=> addr_q == org_q);

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          resume_i,
  input  logic          adv_i,
  input  logic          save_i,
  input  logic [NW-1:0] cnt_init_i,
  output logic          last_o,
  output logic [NW-1:0] saved_o
);
  logic [NW-1:0] cnt_q, cnt_d, sv_q;

  assign last_o  = (cnt_q == NW'(1));
  assign saved_o = sv_q;

  always_comb begin
    cnt_d = cnt_q;
    if (init_i)                          cnt_d = cnt_init_i;
    else if (resume_i)                   cnt_d = sv_q;
    else if (adv_i && cnt_q != '0)       cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sv_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (save_i) sv_q <= cnt_d;
    end
  end

  // R6: one decrement per generated position
  p_cnt_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && cnt_q != '0 && !init_i && !resume_i |=> cnt_q == $past(cnt_q) - NW'(1));

  // R6: a zero count stays zero while running
  p_cnt_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == '0 && !init_i && !resume_i |=> cnt_q == '0);

endmodule

// File: rtl/scan_map.sv
module scan_map #(
  parameter int CW = 12,
  parameter int AW = 20,
  parameter int SW = 4
) (
  input  logic signed [CW-1:0] x_i,
  input  logic signed [CW-1:0] y_i,
  input  logic [SW-1:0]        shift_i,
  output logic                 ovf_o,
  output logic [AW-1:0]        addr_o
);
  localparam int WW = CW + (1 << SW);

  logic [CW-1:0] ux, uy;
  logic [WW-1:0] yw, merged;
  logic          x_ovf, y_ovf;

  assign ux     = unsigned'(x_i);
  assign uy     = unsigned'(y_i);
  assign yw     = WW'(uy) << shift_i;
  assign x_ovf  = x_i[CW-1] | ((ux >> shift_i) != '0);
  assign y_ovf  = y_i[CW-1] | ((yw >> AW) != '0);
  assign ovf_o  = x_ovf | y_ovf;
  assign merged = yw | WW'(ux);
  assign addr_o = AW'(merged);

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic adv_i,
  input  logic final_i,
  output logic run_o,
  output logic done_o
);
  logic run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv_i & final_i & ~start_i;
      if (start_i)                run_q <= 1'b1;
      else if (adv_i && final_i)  run_q <= 1'b0;
      else if (stop_i)            run_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;

  // R5: termination pulse lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/scan_handle_gen.sv
module scan_handle_gen #(
  parameter int CW = 12,
  parameter int AW = 20,
  parameter int NW = 16,
  parameter int SW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 resume_i,
  input  logic                 stop_i,
  input  logic                 save_i,
  input  logic                 end_sel_i,
  input  logic [NW-1:0]        cnt_init_i,
  input  logic [SW-1:0]        shift_i,
  input  logic signed [CW-1:0] x_org_i,
  input  logic signed [CW-1:0] x_span_i,
  input  logic signed [CW-1:0] x_step_i,
  input  logic signed [CW-1:0] x_org_step_i,
  input  logic signed [CW-1:0] x_span_step_i,
  input  logic signed [CW-1:0] x_org_end_i,
  input  logic signed [CW-1:0] x_span_end_i,
  input  logic signed [CW-1:0] y_org_i,
  input  logic signed [CW-1:0] y_span_i,
  input  logic signed [CW-1:0] y_step_i,
  input  logic signed [CW-1:0] y_org_step_i,
  input  logic signed [CW-1:0] y_span_step_i,
  input  logic signed [CW-1:0] y_org_end_i,
  input  logic signed [CW-1:0] y_span_end_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic signed [CW-1:0] out_x_o,
  output logic signed [CW-1:0] out_y_o,
  output logic [AW-1:0]        out_addr_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic [NW-1:0]        saved_cnt_o
);
  import scan_pkg::*;

  localparam int NDIM = 2;

  logic signed [CW-1:0] c_org [NDIM];
  logic signed [CW-1:0] c_span [NDIM];
  logic signed [CW-1:0] c_step [NDIM];
  logic signed [CW-1:0] c_org_step [NDIM];
  logic signed [CW-1:0] c_span_step [NDIM];
  logic signed [CW-1:0] c_org_end [NDIM];
  logic signed [CW-1:0] c_span_end [NDIM];
  logic signed [CW-1:0] pos [NDIM];
  logic [NDIM-1:0]      line_esc, frame_esc;

  logic run, ovf, adv, line_end, final_step, cnt_last, init, resume;
  end_sel_e end_sel;

  assign c_org[0] = x_org_i;             assign c_org[1] = y_org_i;
  assign c_span[0] = x_span_i;           assign c_span[1] = y_span_i;
  assign c_step[0] = x_step_i;           assign c_step[1] = y_step_i;
  assign c_org_step[0] = x_org_step_i;   assign c_org_step[1] = y_org_step_i;
  assign c_span_step[0] = x_span_step_i; assign c_span_step[1] = y_span_step_i;
  assign c_org_end[0] = x_org_end_i;     assign c_org_end[1] = y_org_end_i;
  assign c_span_end[0] = x_span_end_i;   assign c_span_end[1] = y_span_end_i;

  assign end_sel  = end_sel_e'(end_sel_i);
  assign init     = start_i & ~resume_i;
  assign resume   = start_i & resume_i;
  assign adv      = run & ~start_i & (ovf | out_ready_i);
  assign line_end = |line_esc;
  assign final_step = (line_end & (|frame_esc))
                    | ((end_sel == END_ESC_OR_CNT) & cnt_last);

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    scan_slider #(.CW(CW)) i_slider (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_i      (init),
      .resume_i    (resume),
      .adv_i       (adv),
      .wrap_i      (line_end),
      .save_i      (save_i),
      .org_i       (c_org[d]),
      .span_i      (c_span[d]),
      .step_i      (c_step[d]),
      .org_step_i  (c_org_step[d]),
      .span_step_i (c_span_step[d]),
      .org_end_i   (c_org_end[d]),
      .span_end_i  (c_span_end[d]),
      .pos_o       (pos[d]),
      .line_esc_o  (line_esc[d]),
      .frame_esc_o (frame_esc[d])
    );
  end

  scan_counter #(.NW(NW)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init),
    .resume_i   (resume),
    .adv_i      (adv),
    .save_i     (save_i),
    .cnt_init_i (cnt_init_i),
    .last_o     (cnt_last),
    .saved_o    (saved_cnt_o)
  );

  scan_map #(.CW(CW), .AW(AW), .SW(SW)) i_map (
    .x_i     (pos[0]),
    .y_i     (pos[1]),
    .shift_i (shift_i),
    .ovf_o   (ovf),
    .addr_o  (out_addr_o)
  );

  scan_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .adv_i   (adv),
    .final_i (final_step),
    .run_o   (run),
    .done_o  (done_o)
  );

  assign out_valid_o = run & ~ovf;
  assign out_x_o     = pos[0];
  assign out_y_o     = pos[1];
  assign busy_o      = run;

  // R2: a start always opens a run
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  // R7: stalled handle holds
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !start_i && !stop_i
    |=> out_valid_o && $stable(out_addr_o) && $stable(out_x_o) && $stable(out_y_o));

  // R5: termination leaves the block idle
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9: nothing negative is ever presented
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !out_x_o[CW-1] && !out_y_o[CW-1]);

  // R12: stop idles the block
  p_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !busy_o && !out_valid_o);

endmodule

// File: tb/test_scan_handle_gen.sv
`timescale 1ns/1ps
module test_scan_handle_gen;
  localparam int CW = 12;
  localparam int AW = 20;
  localparam int NW = 16;
  localparam int SW = 4;

  typedef struct packed {
    int xo, xs, xst, xost, xsst, xoe, xse;
    int yo, ys, yst, yost, ysst, yoe, yse;
    int sh, esel, cnt;
    int n, first, last;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3 R4 R5 R8 rectangle 4x3
    '{0,3,1,0,0,0,0,    0,0,0,1,0,3,0,     4,0,0, 12,0,35},
    // R4 negative x step
    '{5,2,-1,0,0,0,0,   1,0,0,2,0,6,0,     3,0,0, 12,13,42},
    // R5 span end bound, triangle
    '{0,0,1,0,1,0,3,    0,0,0,1,0,100,0,   4,0,0, 6,0,34},
    // R6 counter stops early
    '{0,3,1,0,0,0,0,    0,0,0,1,0,3,0,     4,1,5, 5,0,16},
    // R6 zero count no effect
    '{0,3,1,0,0,0,0,    0,0,0,1,0,3,0,     4,1,0, 12,0,35},
    // R9 negative x skipped
    '{-1,2,1,0,0,0,0,   0,0,0,1,0,2,0,     2,0,0, 6,0,6},
    // R9 x wider than shift skipped
    '{0,3,1,0,0,0,0,    0,0,0,1,0,2,0,     1,0,0, 4,0,3},
    // R6 counter ignored with end_sel 0
    '{0,3,1,0,0,0,0,    0,0,0,1,0,3,0,     4,0,3, 12,0,35},
    // R5 single handle
    '{7,7,1,1,0,8,0,    2,0,0,0,0,0,0,     4,0,0, 1,39,39},
    // R3 diagonal lock-step
    '{0,3,1,1,0,1,0,    10,100,2,0,0,0,0,  4,0,0, 4,160,259},
    // R4 y escape ends line
    '{0,100,1,2,0,4,0,  0,1,1,0,0,0,0,     4,0,0, 4,0,19},
    // R9 y above address width skipped
    '{0,0,1,0,0,0,0,    31,0,0,1,0,33,0,   15,0,0, 1,1015808,1015808}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, resume_i = 0, stop_i = 0, save_i = 0, end_sel_i = 0;
  logic [NW-1:0] cnt_init_i = '0;
  logic [SW-1:0] shift_i = '0;
  logic signed [CW-1:0] x_org_i = '0, x_span_i = '0, x_step_i = '0, x_org_step_i = '0,
                        x_span_step_i = '0, x_org_end_i = '0, x_span_end_i = '0;
  logic signed [CW-1:0] y_org_i = '0, y_span_i = '0, y_step_i = '0, y_org_step_i = '0,
                        y_span_step_i = '0, y_org_end_i = '0, y_span_end_i = '0;
  logic out_ready_i = 1'b0;
  logic out_valid_o, done_o, busy_o;
  logic signed [CW-1:0] out_x_o, out_y_o;
  logic [AW-1:0] out_addr_o;
  logic [NW-1:0] saved_cnt_o;

  int checks = 0;
  int errs = 0;

  always #4 clk = ~clk;

  scan_handle_gen #(.CW(CW), .AW(AW), .NW(NW), .SW(SW)) i_scan_handle_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .resume_i(resume_i),
    .stop_i(stop_i), .save_i(save_i), .end_sel_i(end_sel_i), .cnt_init_i(cnt_init_i),
    .shift_i(shift_i),
    .x_org_i(x_org_i), .x_span_i(x_span_i), .x_step_i(x_step_i),
    .x_org_step_i(x_org_step_i), .x_span_step_i(x_span_step_i),
    .x_org_end_i(x_org_end_i), .x_span_end_i(x_span_end_i),
    .y_org_i(y_org_i), .y_span_i(y_span_i), .y_step_i(y_step_i),
    .y_org_step_i(y_org_step_i), .y_span_step_i(y_span_step_i),
    .y_org_end_i(y_org_end_i), .y_span_end_i(y_span_end_i),
    .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .out_x_o(out_x_o),
    .out_y_o(out_y_o), .out_addr_o(out_addr_o), .done_o(done_o), .busy_o(busy_o),
    .saved_cnt_o(saved_cnt_o)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    x_org_i = CW'(v.xo);    x_span_i = CW'(v.xs);     x_step_i = CW'(v.xst);
    x_org_step_i = CW'(v.xost); x_span_step_i = CW'(v.xsst);
    x_org_end_i = CW'(v.xoe);   x_span_end_i = CW'(v.xse);
    y_org_i = CW'(v.yo);    y_span_i = CW'(v.ys);     y_step_i = CW'(v.yst);
    y_org_step_i = CW'(v.yost); y_span_step_i = CW'(v.ysst);
    y_org_end_i = CW'(v.yoe);   y_span_end_i = CW'(v.yse);
    shift_i = SW'(v.sh); end_sel_i = v.esel[0]; cnt_init_i = NW'(v.cnt);
  endtask

  task automatic start_scan(input logic res);
    out_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; resume_i = res;
    @(negedge clk);
    start_i = 1'b0; resume_i = 1'b0;
  endtask

  task automatic collect(input int exp_n, input int exp_first, input int exp_last,
                         input string tag);
    int n = 0;
    longint first = -1, last = -1;
    logic got_done = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done_o) begin got_done = 1'b1; break; end
      out_ready_i = (i % 3 != 2);
      if (out_valid_o && out_ready_i) begin
        if (n == 0) first = out_addr_o;
        last = out_addr_o;
        n++;
      end
      @(negedge clk);
    end
    out_ready_i = 1'b0;
    chk(got_done, {tag, " R5 done pulse"}, got_done, 1);
    chk(n == exp_n, {tag, " handle count"}, n, exp_n);
    chk(first == exp_first, {tag, " R2 R8 first address"}, first, exp_first);
    chk(last == exp_last, {tag, " R8 last address"}, last, exp_last);
    @(negedge clk);
    chk(!busy_o && !done_o, {tag, " R5 idle after done"}, {busy_o, done_o}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid_o, "R1 valid", out_valid_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(saved_cnt_o == '0, "R1 saved count", saved_cnt_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      start_scan(1'b0);
      chk(busy_o, $sformatf("vec%0d R2 busy after start", k), busy_o, 1);
      collect(VECS[k].n, VECS[k].first, VECS[k].last, $sformatf("vec%0d", k));
    end

    // R2 R7 first handle and stall hold
    apply(VECS[0]);
    x_org_i = CW'(1); x_span_i = CW'(4); y_org_i = CW'(2);
    start_scan(1'b0);
    chk(out_valid_o && out_x_o == 1 && out_y_o == 2, "R2 first handle x", out_x_o, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid_o && out_addr_o == AW'(33), "R7 stalled address", out_addr_o, 33);
    end
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
    chk(out_x_o == 2 && out_y_o == 2, "R3 step after stall", out_x_o, 2);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;

    // R10 save coinciding with transfer, R12 stop, R11 resume
    apply(VECS[0]);
    end_sel_i = 1'b1; cnt_init_i = NW'(10);
    start_scan(1'b0);
    out_ready_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_x_o == 2 && out_y_o == 0, "R3 third handle", out_x_o, 2);
    save_i = 1'b1;
    @(negedge clk);
    save_i = 1'b0; out_ready_i = 1'b0;
    chk(saved_cnt_o == NW'(7), "R10 saved count", saved_cnt_o, 7);
    chk(out_x_o == 3 && out_y_o == 0, "R10 live position", out_x_o, 3);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(!busy_o && !out_valid_o, "R12 stopped", busy_o, 0);
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (done_o) seen = 1'b1;
      end
      chk(!seen, "R12 no done after stop", seen, 0);
    end
    x_org_i = CW'(2); y_org_i = CW'(2);
    start_scan(1'b1);
    chk(out_valid_o && out_x_o == 3 && out_y_o == 0, "R11 resumed x", out_x_o, 3);
    chk(out_y_o == 0, "R11 resumed y", out_y_o, 0);
    x_org_i = CW'(0); y_org_i = CW'(0);
    collect(7, 3, 33, "R11 R10 resumed run");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule